// File: doc/BRIEF.md
# Wait-Balancing Read/Write Dispatch Selector

This block sits in front of a flash channel controller and picks the next transaction to issue. It sees up to four candidates: one read waiting in a read slot, one write waiting in a write slot, and two queues of pending garbage-collection work, one of reads and one of writes. Each slot carries two service-time figures: memory access time and transfer time. The block counts how many cycles each slot has been waiting.

The block gives neither side a fixed priority. It compares how long each slot has waited relative to that slot's own service time. When the read's normalized wait is at least as large as the write's, the read goes next. When the write side wins, the block may first issue a burst of garbage-collection requests. An external estimator sets the burst length through a budget input. The block then issues the write. The burst is clipped to the work that is actually pending, and garbage-collection reads go before garbage-collection writes. One transaction leaves per valid/ready handshake.

Top module: `wb_dispatch_sel`

## Requirements
- R1: Loading a slot (`rd_load`/`wr_load` high at a clock edge) clears that slot's wait count to 0. After that, the count rises by one at every edge while the slot's valid input is high.
- R2: With both slots valid and no burst under way, the read is offered when rd_wait·(wr_mem_t+wr_xfer_t) ≥ wr_wait·(rd_mem_t+rd_xfer_t); otherwise the write side is served. An exact tie goes to the read.
- R3: With only one slot valid, that slot's side is served. Read-only gives kind 0 (read). Write-only gives kind 1 (write), or a burst as described in R5.
- R4: With neither slot valid and no burst under way, `dsp_valid` is low.
- R5: When the write side is chosen, the block first issues N = min(gc_budget, gcr_pend+gcw_pend) garbage-collection requests. Kind 2 (GC read) is used while gcr_pend is non-zero, and kind 3 (GC write) after that.
- R6: After the last request of a burst, the next offer is the write (kind 1). No read is offered until that write has been taken. With N = 0, the write is offered straight away.
- R7: When the read wins, no garbage-collection request is offered ahead of it, even when GC work is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_vld | input | 1 | Read slot holds a transaction |
| rd_load | input | 1 | A new transaction enters the read slot at this edge |
| rd_mem_t | input | TW | Read memory access time |
| rd_xfer_t | input | TW | Read transfer time |
| wr_vld | input | 1 | Write slot holds a transaction |
| wr_load | input | 1 | A new transaction enters the write slot at this edge |
| wr_mem_t | input | TW | Write memory access time |
| wr_xfer_t | input | TW | Write transfer time |
| gcr_pend | input | CW | Number of pending GC reads |
| gcw_pend | input | CW | Number of pending GC writes |
| gc_budget | input | CW | Maximum number of GC requests allowed ahead of a write |
| dsp_valid | output | 1 | A dispatch is offered |
| dsp_ready | input | 1 | Channel controller accepts the offer |
| dsp_kind | output | 2 | 0 read, 1 write, 2 GC read, 3 GC write |

## Verification
The offer (`dsp_valid`, `dsp_kind`) is combinational from the current inputs and registered state. It is therefore due in the same cycle the inputs are applied, and the bench samples it one time step after each falling edge. Wait counts follow R1: a slot loaded at edge k shows a count of m after edge k+m. The bench sets the load times so that the counts reach the intended ages exactly at the sampling point. A burst moves forward one step per accepted handshake. After each rising edge with the handshake, the bench lowers its own model of the pending counts before it checks the next offer.

// File: rtl/wb_sel_pkg.sv
`timescale 1ns/1ps
// Shared types of the wait-balancing dispatch selector.
package wb_sel_pkg;
    // Dispatch kind; the encoding is visible on dsp_kind.
    typedef enum logic [1:0] {
        K_RD  = 2'd0,
        K_WR  = 2'd1,
        K_GCR = 2'd2,
        K_GCW = 2'd3
    } kind_e;

    // Selector state: free choice, or committed to the write side.
    typedef enum logic {
        ST_PICK  = 1'b0,
        ST_WSIDE = 1'b1
    } sel_st_e;
endpackage

// File: rtl/wb_wait_ctr.sv
`timescale 1ns/1ps
// Per-slot wait counter.
// Clears when the slot is loaded. Rises by one each cycle while the slot is
// valid, and saturates at its maximum value.
// Assumes load and valid are synchronous to clk.
module wb_wait_ctr #(
    parameter int WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          vld,
    output logic [WW-1:0] wait_o
);
    localparam logic [WW-1:0] MAXV = '1;

    // Age the slot, restarting on each load.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            wait_o <= '0;
        else if (vld && wait_o != MAXV)
            wait_o <= wait_o + 1'b1;
    end
endmodule

// File: rtl/wb_pw_cmp.sv
`timescale 1ns/1ps
// Proportional-wait comparator.
// Decides whether rd_wait/rd_cost >= wr_wait/wr_cost. It avoids division by
// cross-multiplying the two sides. Ties resolve to the read.
// Assumes both slots are valid when the result is used.
module wb_pw_cmp #(
    parameter int WW = 16,
    parameter int TW = 8
) (
    input  logic [WW-1:0] rd_wait,
    input  logic [WW-1:0] wr_wait,
    input  logic [TW-1:0] rd_mem_t,
    input  logic [TW-1:0] rd_xfer_t,
    input  logic [TW-1:0] wr_mem_t,
    input  logic [TW-1:0] wr_xfer_t,
    output logic          rd_wins
);
    localparam int CSW = TW + 1;
    localparam int PW  = WW + CSW;

    logic [CSW-1:0] rd_cost, wr_cost;
    logic [PW-1:0]  lhs, rhs;

    // Cross-multiplied comparison of the two normalized waits.
    always_comb begin
        rd_cost = {1'b0, rd_mem_t} + {1'b0, rd_xfer_t};
        wr_cost = {1'b0, wr_mem_t} + {1'b0, wr_xfer_t};
        lhs     = PW'(rd_wait) * PW'(wr_cost);
        rhs     = PW'(wr_wait) * PW'(rd_cost);
        rd_wins = (lhs >= rhs);
    end
endmodule

// File: rtl/wb_dispatch_sel.sv
`timescale 1ns/1ps
// Wait-balancing dispatch selector (top).
// Offers one of: the read slot, the write slot, or a GC read/write. When the
// write side wins, a burst of min(budget, pending) GC requests (reads first)
// is issued, and then the write. The offer is re-evaluated every cycle until
// a burst has started; after that the block stays on the write side.
// Assumes: the write slot stays valid until its write is taken. The GC
// pending counts drop by one after each accepted GC request of that kind.
module wb_dispatch_sel
    import wb_sel_pkg::*;
#(
    parameter int WW = 16,
    parameter int TW = 8,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_vld,
    input  logic          rd_load,
    input  logic [TW-1:0] rd_mem_t,
    input  logic [TW-1:0] rd_xfer_t,
    input  logic          wr_vld,
    input  logic          wr_load,
    input  logic [TW-1:0] wr_mem_t,
    input  logic [TW-1:0] wr_xfer_t,
    input  logic [CW-1:0] gcr_pend,
    input  logic [CW-1:0] gcw_pend,
    input  logic [CW-1:0] gc_budget,
    output logic          dsp_valid,
    input  logic          dsp_ready,
    output logic [1:0]    dsp_kind
);
    localparam int NW = CW + 1;

    logic [WW-1:0] rd_wait, wr_wait;
    logic          rd_wins;
    sel_st_e       st_q;
    logic [NW-1:0] gc_left_q;
    logic [NW-1:0] pend_sum, burst_n;
    kind_e         gc_kind, kind;
    logic          read_side, gc_go, fire, is_gc;

    wb_wait_ctr #(.WW(WW)) u_rd_ctr (
        .clk(clk), .rst_n(rst_n), .load(rd_load), .vld(rd_vld), .wait_o(rd_wait)
    );

    wb_wait_ctr #(.WW(WW)) u_wr_ctr (
        .clk(clk), .rst_n(rst_n), .load(wr_load), .vld(wr_vld), .wait_o(wr_wait)
    );

    wb_pw_cmp #(.WW(WW), .TW(TW)) u_cmp (
        .rd_wait(rd_wait), .wr_wait(wr_wait),
        .rd_mem_t(rd_mem_t), .rd_xfer_t(rd_xfer_t),
        .wr_mem_t(wr_mem_t), .wr_xfer_t(wr_xfer_t),
        .rd_wins(rd_wins)
    );

    // Burst length and the GC kind to issue next.
    always_comb begin
        pend_sum  = {1'b0, gcr_pend} + {1'b0, gcw_pend};
        burst_n   = ({1'b0, gc_budget} < pend_sum) ? {1'b0, gc_budget} : pend_sum;
        gc_kind   = (gcr_pend != '0) ? K_GCR : K_GCW;
        read_side = rd_vld && (!wr_vld || rd_wins);
        gc_go     = (gc_left_q != '0) && (pend_sum != '0);
    end

    // Build the offer from the state and the candidates.
    always_comb begin
        dsp_valid = 1'b0;
        kind      = K_RD;
        if (st_q == ST_PICK) begin
            if (read_side) begin
                dsp_valid = 1'b1;
                kind      = K_RD;
            end else if (wr_vld) begin
                dsp_valid = 1'b1;
                kind      = (burst_n != '0) ? gc_kind : K_WR;
            end
        end else begin
            dsp_valid = gc_go || wr_vld;
            kind      = gc_go ? gc_kind : K_WR;
        end
        fire  = dsp_valid && dsp_ready;
        is_gc = (kind == K_GCR) || (kind == K_GCW);
    end

    assign dsp_kind = kind;

    // Track the burst: enter on the first GC, leave when the write is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_PICK;
            gc_left_q <= '0;
        end else if (fire) begin
            if (st_q == ST_PICK) begin
                if (is_gc) begin
                    st_q      <= ST_WSIDE;
                    gc_left_q <= burst_n - 1'b1;
                end
            end else if (is_gc) begin
                gc_left_q <= gc_left_q - 1'b1;
            end else begin
                st_q      <= ST_PICK;
                gc_left_q <= '0;
            end
        end
    end
endmodule

// File: rtl/wb_dispatch_sel_chk.sv
`timescale 1ns/1ps
// Port-level checker for wb_dispatch_sel, bound to every instance.
module wb_dispatch_sel_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_vld,
    input logic          wr_vld,
    input logic [CW-1:0] gcr_pend,
    input logic [CW-1:0] gcw_pend,
    input logic          dsp_valid,
    input logic          dsp_ready,
    input logic [1:0]    dsp_kind
);
    // R4: nothing to serve means no offer.
    p_idle_no_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_vld && !wr_vld && gcr_pend == '0 && gcw_pend == '0) |-> !dsp_valid);

    // R3: a lone valid read slot is offered as a read.
    p_lone_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld && !wr_vld && gcr_pend == '0 && gcw_pend == '0 && dsp_valid)
        |-> dsp_kind == 2'd0);

    // R3: a lone valid write slot never yields a read offer.
    p_lone_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !rd_vld && dsp_valid) |-> dsp_kind != 2'd0);

    // R5: GC writes only once no GC read is pending.
    p_gc_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_kind == 2'd3) |-> gcr_pend == '0);

    // R6: after an accepted GC request, no read is offered.
    p_no_read_after_gc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_ready && dsp_kind[1]) |=> !(dsp_valid && dsp_kind == 2'd0));
endmodule

bind wb_dispatch_sel wb_dispatch_sel_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .wr_vld(wr_vld),
    .gcr_pend(gcr_pend), .gcw_pend(gcw_pend),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_kind(dsp_kind)
);

// File: tb/wb_dispatch_sel_test.sv
`timescale 1ns/1ps
module wb_dispatch_sel_test;
    localparam int WW = 16;
    localparam int TW = 8;
    localparam int CW = 6;
    localparam int NV = 6;
    // Vectors: read age, write age, read mem/xfer, write mem/xfer.
    localparam int unsigned V_RA[NV] = '{10, 3, 6, 8, 4, 1};
    localparam int unsigned V_WA[NV] = '{ 5, 20, 6, 4, 8, 30};
    localparam int unsigned V_RM[NV] = '{ 2, 2, 4, 2, 1, 1};
    localparam int unsigned V_RX[NV] = '{ 1, 2, 4, 2, 1, 1};
    localparam int unsigned V_WM[NV] = '{20, 8, 2, 8, 2, 5};
    localparam int unsigned V_WX[NV] = '{ 4, 8, 2, 8, 2, 5};

    logic clk = 1'b0, rst_n = 1'b0;
    logic rd_vld = 0, rd_load = 0, wr_vld = 0, wr_load = 0, dsp_ready = 0;
    logic [TW-1:0] rd_mem_t = 0, rd_xfer_t = 0, wr_mem_t = 0, wr_xfer_t = 0;
    logic [CW-1:0] gcr_pend = 0, gcw_pend = 0, gc_budget = 0;
    logic dsp_valid;
    logic [1:0] dsp_kind;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    wb_dispatch_sel #(.WW(WW), .TW(TW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .rd_vld(rd_vld), .rd_load(rd_load), .rd_mem_t(rd_mem_t), .rd_xfer_t(rd_xfer_t),
        .wr_vld(wr_vld), .wr_load(wr_load), .wr_mem_t(wr_mem_t), .wr_xfer_t(wr_xfer_t),
        .gcr_pend(gcr_pend), .gcw_pend(gcw_pend), .gc_budget(gc_budget),
        .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_kind(dsp_kind)
    );

    task automatic chk(input string rq, input logic ev, input logic [1:0] ek);
        n_run++;
        if (dsp_valid !== ev || (ev && dsp_kind !== ek)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b kind=%0d, expected valid=%0b kind=%0d",
                     rq, dsp_valid, dsp_kind, ev, ek);
        end
    endtask

    // Load both slots so that, at the returned sampling point, the read has
    // waited ra cycles and the write wa cycles (R1).
    task automatic age(input int unsigned ra, input int unsigned wa,
                       input int unsigned rm, input int unsigned rx,
                       input int unsigned wm, input int unsigned wx);
        int unsigned t;
        t = (ra > wa) ? ra : wa;
        dsp_ready = 0;
        rd_mem_t = TW'(rm); rd_xfer_t = TW'(rx);
        wr_mem_t = TW'(wm); wr_xfer_t = TW'(wx);
        for (int unsigned c = 0; c <= t; c++) begin
            rd_load = (c == t - ra);
            wr_load = (c == t - wa);
            if (rd_load) rd_vld = 1;
            if (wr_load) wr_vld = 1;
            @(negedge clk);
        end
        rd_load = 0; wr_load = 0;
        #1;
    endtask

    // One handshake step: check the offer, take it, update the GC model.
    task automatic step(input string rq, input logic [1:0] ek);
        logic [1:0] k;
        @(negedge clk);
        dsp_ready = 1;
        #1 chk(rq, 1'b1, ek);
        k = dsp_kind;
        @(posedge clk);
        #1;
        if (k == 2'd2) gcr_pend--;
        if (k == 2'd3) gcw_pend--;
        if (k == 2'd1) wr_vld = 0;
        if (k == 2'd0) rd_vld = 0;
        dsp_ready = 0;
    endtask

    task automatic clear_slots();
        @(negedge clk);
        rd_vld = 0; wr_vld = 0; dsp_ready = 0;
        gcr_pend = 0; gcw_pend = 0; gc_budget = 0;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1 chk("R4 reset state", 1'b0, 2'd0);

        // Vector table: R1 aging and R2 ratio comparison, ties to the read.
        for (int i = 0; i < NV; i++) begin
            logic [1:0] ek;
            ek = (V_RA[i] * (V_WM[i] + V_WX[i]) >= V_WA[i] * (V_RM[i] + V_RX[i]))
                 ? 2'd0 : 2'd1;
            age(V_RA[i], V_WA[i], V_RM[i], V_RX[i], V_WM[i], V_WX[i]);
            chk($sformatf("R1/R2 vector %0d", i), 1'b1, ek);
            clear_slots();
        end

        // R3: lone slots.
        rd_mem_t = 3; rd_xfer_t = 3; rd_vld = 1;
        #1 chk("R3 lone read", 1'b1, 2'd0);
        @(negedge clk); rd_vld = 0; wr_vld = 1;
        #1 chk("R3 lone write", 1'b1, 2'd1);

        // R4: no slot valid, GC pending, no burst under way.
        @(negedge clk); wr_vld = 0; gcr_pend = 4; gc_budget = 4;
        #1 chk("R4 no slot with GC pending", 1'b0, 2'd0);
        clear_slots();

        // R5/R6: burst of min(3, 2+5)=3: GCR, GCR, GCW, then write.
        gcr_pend = 2; gcw_pend = 5; gc_budget = 3;
        age(1, 20, 2, 2, 2, 2);
        step("R5 burst 1 GC read", 2'd2);
        step("R5 burst 2 GC read", 2'd2);
        step("R5 burst 3 GC write", 2'd3);
        step("R6 write after burst", 2'd1);
        clear_slots();

        // R5/R6: budget 5 clipped to pending 1+1.
        gcr_pend = 1; gcw_pend = 1; gc_budget = 5;
        age(1, 20, 2, 2, 2, 2);
        step("R5 clipped 1 GC read", 2'd2);
        step("R5 clipped 2 GC write", 2'd3);
        step("R6 write after clipped burst", 2'd1);
        clear_slots();

        // R6: budget 0 issues the write at once.
        gcr_pend = 3; gcw_pend = 3; gc_budget = 0;
        age(1, 20, 2, 2, 2, 2);
        step("R6 zero budget write", 2'd1);
        clear_slots();

        // R7: read wins, so no GC request is offered ahead of it.
        gcr_pend = 3; gcw_pend = 3; gc_budget = 4;
        age(20, 1, 2, 2, 2, 2);
        step("R7 read wins with GC pending", 2'd0);
        clear_slots();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule